// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs the read and write cycles of one chip-select region on an external parallel bus. A request carries a direction flag and a burst length. For every beat the block raises the matching strobe and counts down a programmed number of wait cycles. It can then hold the beat open for longer while an active-low wait pin is low. Each beat closes with an end cycle, which the block marks on `beat_end`.

Single accesses use one 5-bit wait count for reads and another for writes. A page-mode burst runs its first beat with those same counts. Every later beat uses shorter 3-bit page counts, and the wait pin is checked again after each page wait. The wait pin passes through a two-flop synchronizer. After the last end cycle the block spends one hold cycle, during which it pulses `done`, and then returns to idle.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset the block is idle: `idle`=1, `rd_stb`=0, `wr_stb`=0, `done`=0, `beat_end`=0.
- R2: Beat 0 inserts `cfg_rd_wait` programmed wait cycles when `req_write`=0 and `cfg_wr_wait` cycles when `req_write`=1. Both fields are 5 bits wide.
- R3: In a burst, beats 1 and later insert `cfg_pg_rd_wait` or `cfg_pg_wr_wait` cycles. Both fields are 3 bits wide. With no external stretching, a beat with W programmed waits lasts W+2 strobe cycles: W wait cycles, one sampling cycle and the end cycle.
- R4: When `cfg_ext_en`=0, the level of `wait_n` has no effect on any output.
- R5: The programmed wait cycles are always inserted in full, whatever level `wait_n` has. Only after they finish is the synchronized `wait_n` sampled. Each sample that is low (with `cfg_ext_en`=1) adds one more cycle to the beat.
- R6: The end cycle of a beat, shown by `beat_end`=1, follows the cycle in which the synchronized wait is first seen high.
- R7: `wait_n` passes through two flip-flops. When `wait_n` rises just before a clock edge while the beat is waiting on it, `beat_end` is high in the third cycle after that edge.
- R8: A programmed wait count of 0 makes sampling start in the first cycle of the beat.
- R9: Exactly one strobe is asserted from the first cycle of each beat through its end cycle: `rd_stb` for reads and `wr_stb` for writes.
- R10: `done` is high for one cycle, which is the hold cycle directly after the final end cycle. `idle` returns in the next cycle. `req_valid` is ignored unless `idle`=1.
- R11: `req_len` is the number of beats minus one. `beat_idx` counts the beats from 0 up to `req_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Number of beats minus one |
| cfg_rd_wait | input | 5 | Wait count for reads outside page beats |
| cfg_wr_wait | input | 5 | Wait count for writes outside page beats |
| cfg_pg_rd_wait | input | 3 | Wait count for page read beats |
| cfg_pg_wr_wait | input | 3 | Wait count for page write beats |
| cfg_ext_en | input | 1 | Enables stretching by the wait pin |
| wait_n | input | 1 | Asynchronous active-low wait pin |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| beat_idx | output | LEN_W | Index of the current beat |
| beat_end | output | 1 | End cycle of a beat |
| done | output | 1 | Hold cycle after the final beat |
| idle | output | 1 | Ready for a request |

## Verification
Two events can fall in the same cycle: the programmed wait count running out, and the synchronized wait line going high. When that happens, the sample taken right after the count runs out must already see the line high, and the end cycle follows one cycle later. The bench provokes this with short random wait counts while the pin toggles at random on every cycle. A cycle model in the bench, with its own two-stage copy of the pin path, predicts every strobe and end cycle, and the outputs are compared on every cycle.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

    localparam int NRM_W = 5;
    localparam int PG_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_SAMP,
        ST_TEND,
        ST_HOLD
    } xbw_state_e;

    typedef struct packed {
        logic [NRM_W-1:0] rd_nrm;
        logic [NRM_W-1:0] wr_nrm;
        logic [PG_W-1:0]  rd_pg;
        logic [PG_W-1:0]  wr_pg;
        logic             ext_en;
    } xbw_cfg_t;

    function automatic logic [NRM_W-1:0] pick_wait(input xbw_cfg_t c,
                                                   input logic is_wr,
                                                   input logic is_page);
        logic [NRM_W-1:0] r;
        if (is_page)
            r = is_wr ? {{(NRM_W-PG_W){1'b0}}, c.wr_pg}
                      : {{(NRM_W-PG_W){1'b0}}, c.rd_pg};
        else
            r = is_wr ? c.wr_nrm : c.rd_nrm;
        return r;
    endfunction

endpackage

// File: rtl/xbw_sync.sv
module xbw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xbw_wait_cnt.sv
module xbw_wait_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
    import xbw_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  xbw_cfg_t         cfg_in,
    input  logic             wait_s,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic [NRM_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic [LEN_W-1:0] beat_idx,
    output logic             beat_end,
    output logic             done,
    output logic             idle
);
    xbw_state_e       state_q, state_d;
    xbw_cfg_t         cfg_q;
    logic             wr_q;
    logic [LEN_W-1:0] len_q, beat_q;
    logic             accept, last_beat, in_beat, ext_hold;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == len_q);
    assign ext_hold  = cfg_q.ext_en && !wait_s;

    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept) begin
            cnt_load = 1'b1;
            cnt_val  = pick_wait(cfg_in, req_write, 1'b0);
        end else if (state_q == ST_TEND && !last_beat) begin
            cnt_load = 1'b1;
            cnt_val  = pick_wait(cfg_q, wr_q, 1'b1);
        end
    end

    assign cnt_dec = (state_q == ST_PROG);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept) state_d = (cnt_val == '0) ? ST_SAMP : ST_PROG;
            ST_PROG: if (cnt_last) state_d = ST_SAMP;
            ST_SAMP: if (!ext_hold) state_d = ST_TEND;
            ST_TEND: begin
                if (last_beat) state_d = ST_HOLD;
                else           state_d = (cnt_val == '0) ? ST_SAMP : ST_PROG;
            end
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            len_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q  <= cfg_in;
                wr_q   <= req_write;
                len_q  <= req_len;
                beat_q <= '0;
            end else if (state_q == ST_TEND && !last_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign in_beat  = (state_q == ST_PROG) || (state_q == ST_SAMP) || (state_q == ST_TEND);
    assign rd_stb   = in_beat && !wr_q;
    assign wr_stb   = in_beat && wr_q;
    assign beat_idx = beat_q;
    assign beat_end = (state_q == ST_TEND);
    assign done     = (state_q == ST_HOLD);
    assign idle     = (state_q == ST_IDLE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!rd_stb && !wr_stb && !done)); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb)); // R9
    AST_PROG_FULL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && !cnt_last) |=> (state_q == ST_PROG)); // R5
    AST_LOW_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMP && cfg_q.ext_en && !wait_s) |=> (state_q == ST_SAMP)); // R5
    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMP && !cfg_q.ext_en) |=> (state_q == ST_TEND)); // R4
    AST_HIGH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMP && wait_s) |=> beat_end); // R6
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(beat_end)); // R10
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> idle); // R10
    AST_BUSY_HOLDS_DIR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG) |=> $stable(wr_q)); // R10
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        beat_q <= len_q); // R11
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbw_pkg::*;
#(
    parameter int LEN_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic [4:0]       cfg_rd_wait,
    input  logic [4:0]       cfg_wr_wait,
    input  logic [2:0]       cfg_pg_rd_wait,
    input  logic [2:0]       cfg_pg_wr_wait,
    input  logic             cfg_ext_en,
    input  logic             wait_n,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic [LEN_W-1:0] beat_idx,
    output logic             beat_end,
    output logic             done,
    output logic             idle
);
    xbw_cfg_t         cfg;
    logic             wait_s, cnt_last, cnt_load, cnt_dec;
    logic [NRM_W-1:0] cnt_val;

    assign cfg.rd_nrm = cfg_rd_wait;
    assign cfg.wr_nrm = cfg_wr_wait;
    assign cfg.rd_pg  = cfg_pg_rd_wait;
    assign cfg.wr_pg  = cfg_pg_wr_wait;
    assign cfg.ext_en = cfg_ext_en;

    xbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (wait_n),
        .q   (wait_s)
    );

    xbw_wait_cnt #(.W(NRM_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    xbw_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_len   (req_len),
        .cfg_in    (cfg),
        .wait_s    (wait_s),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_dec   (cnt_dec),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .beat_idx  (beat_idx),
        .beat_end  (beat_end),
        .done      (done),
        .idle      (idle)
    );
endmodule

// File: tb/tb_xbus_wait_ctrl.sv
module tb_xbus_wait_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_len = '0;
    logic [4:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
    logic [2:0] cfg_pg_rd_wait = '0, cfg_pg_wr_wait = '0;
    logic cfg_ext_en = 1'b0;
    logic wait_n = 1'b1;
    logic rd_stb, wr_stb, beat_end, done, idle;
    logic [2:0] beat_idx;

    int total = 0;
    int bad = 0;
    int blen [0:7];
    int nbeats;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_wait_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .cfg_pg_rd_wait(cfg_pg_rd_wait), .cfg_pg_wr_wait(cfg_pg_wr_wait),
        .cfg_ext_en(cfg_ext_en), .wait_n(wait_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .beat_idx(beat_idx), .beat_end(beat_end), .done(done), .idle(idle)
    );

    // Reference cycle model: 0 idle, 1 programmed wait, 2 sampling, 3 end, 4 hold
    int   m_st, m_cnt, m_beat, m_len;
    logic m_wr, m_en, m_s1, m_s2;
    logic [2:0] m_prd, m_pwr;

    function automatic int beat_cycles(input int w);
        return w + 2;
    endfunction

    always @(posedge clk) begin
        logic ws;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_beat = 0; m_len = 0;
            m_wr = 0; m_en = 0; m_s1 = 1; m_s2 = 1; m_prd = 0; m_pwr = 0;
        end else begin
            ws = m_s2;
            m_s2 = m_s1;
            m_s1 = wait_n;
            case (m_st)
                0: if (req_valid) begin
                    m_wr = req_write; m_len = int'(req_len); m_beat = 0;
                    m_en = cfg_ext_en; m_prd = cfg_pg_rd_wait; m_pwr = cfg_pg_wr_wait;
                    m_cnt = req_write ? int'(cfg_wr_wait) : int'(cfg_rd_wait);
                    m_st = (m_cnt == 0) ? 2 : 1;
                end
                1: begin m_cnt = m_cnt - 1; if (m_cnt == 0) m_st = 2; end
                2: if (!(m_en && !ws)) m_st = 3;
                3: if (m_beat == m_len) m_st = 4;
                   else begin
                       m_beat = m_beat + 1;
                       m_cnt = m_wr ? int'(m_pwr) : int'(m_prd);
                       m_st = (m_cnt == 0) ? 2 : 1;
                   end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic inb;
            inb = (m_st >= 1 && m_st <= 3);
            chk("R9", "rd_stb", int'(rd_stb), int'(inb && !m_wr));
            chk("R9", "wr_stb", int'(wr_stb), int'(inb && m_wr));
            chk("R6", "beat_end", int'(beat_end), int'(m_st == 3));
            chk("R10", "done", int'(done), int'(m_st == 4));
            chk("R10", "idle", int'(idle), int'(m_st == 0));
            chk("R11", "beat_idx", int'(beat_idx), m_beat);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // pmode: 0 pin high, 1 pin low, 2 random pin and stray requests
    task automatic do_txn(input logic wr, input int len, input int rw, input int ww,
                          input int prw, input int pww, input logic en, input int pmode);
        int cur;
        @(negedge clk);
        while (!idle) @(negedge clk);
        cfg_rd_wait = 5'(rw); cfg_wr_wait = 5'(ww);
        cfg_pg_rd_wait = 3'(prw); cfg_pg_wr_wait = 3'(pww); cfg_ext_en = en;
        req_write = wr; req_len = 3'(len); req_valid = 1'b1;
        wait_n = (pmode == 1) ? 1'b0 : 1'b1;
        cur = 0; nbeats = 0;
        for (int i = 0; i < 8; i++) blen[i] = 0;
        forever begin
            @(negedge clk);
            req_valid = (pmode == 2) ? ($urandom % 6 == 0) : 1'b0;
            req_write = $urandom % 2;
            if (pmode == 2) wait_n = ($urandom % 4 != 0);
            if (rd_stb || wr_stb) cur++;
            if (beat_end) begin
                if (nbeats < 8) blen[nbeats] = cur;
                nbeats++; cur = 0;
            end
            if (done) begin req_valid = 1'b0; break; end
        end
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "idle after reset", int'(idle), 1);
        chk("R1", "strobes after reset", int'(rd_stb | wr_stb), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "beat_end after reset", int'(beat_end), 0);

        // R2/R4: read, 3 waits, pin low but stretching disabled
        do_txn(1'b0, 0, 3, 9, 0, 0, 1'b0, 1);
        chk("R4", "read beat len with pin low", blen[0], beat_cycles(3));
        // R2: write uses write count
        do_txn(1'b1, 0, 1, 7, 0, 0, 1'b0, 0);
        chk("R2", "write beat len", blen[0], beat_cycles(7));
        // R3/R11: four-beat read burst
        do_txn(1'b0, 3, 4, 0, 2, 6, 1'b0, 0);
        chk("R11", "beat count", nbeats, 4);
        chk("R2", "burst first beat", blen[0], beat_cycles(4));
        for (int b = 1; b < 4; b++) chk("R3", "page read beat", blen[b], beat_cycles(2));
        // R3: write burst with zero page wait
        do_txn(1'b1, 2, 0, 5, 3, 0, 1'b1, 0);
        chk("R3", "page write beat 1", blen[1], beat_cycles(0));
        // R8: zero wait, stretching on, pin high
        do_txn(1'b0, 0, 0, 0, 0, 0, 1'b1, 0);
        chk("R8", "zero wait beat", blen[0], 2);
        // R5: programmed waits in full with stretching on and pin high
        do_txn(1'b0, 0, 6, 0, 0, 0, 1'b1, 0);
        chk("R5", "full programmed wait", blen[0], beat_cycles(6));

        // R5/R7: pin held low, then released
        @(negedge clk);
        while (!idle) @(negedge clk);
        cfg_rd_wait = 5'd1; cfg_ext_en = 1'b1; req_write = 1'b0; req_len = 3'd0;
        wait_n = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk("R5", "strobe held while pin low", int'(rd_stb), 1);
        chk("R5", "no end while pin low", int'(beat_end), 0);
        wait_n = 1'b1;
        k = 0;
        while (k < 10) begin
            @(negedge clk);
            k++;
            if (beat_end) break;
        end
        chk("R7", "cycles from release to end", k, 3);
        @(negedge clk);
        chk("R10", "done after final end", int'(done), 1);
        @(negedge clk);
        chk("R10", "idle after hold", int'(idle), 1);

        // Random transactions with random pin activity
        void'($urandom(32'h5eed_1234));
        for (int t = 0; t < 250; t++) begin
            int rw, ww, ln;
            rw = $urandom % 32; ww = $urandom % 32; ln = $urandom % 8;
            if ($urandom % 3 == 0) begin rw = rw % 3; ww = ww % 3; end
            do_txn($urandom % 2, ln, rw, ww, $urandom % 8, $urandom % 8,
                   $urandom % 2, 2);
            chk("R11", "random beat count", nbeats, ln + 1);
        end

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule